// File: doc/BRIEF.md
# Move-Wide Immediate Insertion Unit

This block builds a 64-bit register value one 16-bit chunk at a time. Each operation takes a 16-bit immediate and a halfword select, which places the chunk at bit offset 0, 16, 32 or 48. It then does one of three things. The zeroing form clears every other bit. The inverting form builds the zeroing result and then flips every bit of it. The keep form leaves every other bit of the held destination as it was.

A destination register inside the block supplies the prior value for the keep form. It takes the computed result on an accepted strobe. Four operations therefore compose any 64-bit constant: one zeroing insert at halfword 0, then keep inserts at halfwords 1, 2 and 3.

A mode input selects 32-bit operation. In that mode only the two lower halfwords may be addressed, and the upper word of every result is cleared. Encodings that cannot be honoured raise an illegal flag. An illegal operation writes nothing.

Top module: `mwi_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the destination register is cleared to zero. This applies both at start-up and in the middle of a run.
- R2: Opcode 2'b10 (zeroing) gives a result with `imm` at bits [16*hw_sel+15 : 16*hw_sel] and zero in every other bit.
- R3: Opcode 2'b00 (inverting) gives the bitwise inverse of the R2 result for the same `imm` and `hw_sel`.
- R4: Opcode 2'b11 (keep) gives a result with `imm` in the selected halfword and the held destination's bits everywhere else.
- R5: With `wide_mode` low (32-bit mode), `hw_sel` values 0 and 1 are legal, and result bits [63:32] are zero for every opcode.
- R6: `illegal` is high when the opcode is 2'b01, or when `wide_mode` is low and `hw_sel` is 2 or 3. While `illegal` is high, `result` is all zeros.
- R7: On a rising edge where `op_valid` is high and `illegal` is low, the destination takes `result`, and the new value shows on `dest` from that edge on. In every other case `dest` holds.
- R8: A zeroing insert of 0x7788 at halfword 0, followed by keep inserts of 0x5566, 0x3344 and 0x1122 at halfwords 1, 2 and 3, leaves `dest` = 0x1122334455667788.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Strobe requesting a destination update |
| op_code | input | 2 | 00 invert, 01 reserved, 10 zero, 11 keep |
| imm | input | 16 | Immediate chunk |
| hw_sel | input | 2 | Halfword select; offset is 16*hw_sel |
| wide_mode | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| result | output | 64 | Combinational result of the present operation |
| illegal | output | 1 | Combinational illegal-encoding flag |
| dest | output | 64 | Held destination value |

## Verification
`result` and `illegal` are combinational from the inputs and the held destination. The bench drives inputs on the falling edge and compares these two outputs 1 ns later, within the same cycle. `dest` moves one rising edge after an accepted strobe, so its check is made 1 ns after that edge. That check uses a bench model that updated at the same edge. The reset check samples `dest` after the first edge with `rst_n` low.

// File: rtl/mwi_pkg.sv
// Package mwi_pkg
// Holds the opcode encoding shared by the decode, merge and top modules.
// Assumes the 2-bit opcode field of the move-wide operation.
package mwi_pkg;

    typedef enum logic [1:0] {
        MW_INV  = 2'b00,
        MW_RSVD = 2'b01,
        MW_ZERO = 2'b10,
        MW_KEEP = 2'b11
    } mw_op_e;

endpackage

// File: rtl/mwi_lane_place.sv
// Module mwi_lane_place
// Places a CHUNK_W-bit immediate into the lane picked by hw_sel and
// produces a mask of that lane. Assumes DATA_W is a whole multiple of CHUNK_W.
module mwi_lane_place #(
    parameter int DATA_W  = 64,
    parameter int CHUNK_W = 16,
    parameter int LANES   = DATA_W / CHUNK_W,
    parameter int SEL_W   = $clog2(LANES)
) (
    input  logic [CHUNK_W-1:0] imm,
    input  logic [SEL_W-1:0]   hw_sel,
    output logic [DATA_W-1:0]  placed,
    output logic [DATA_W-1:0]  lane_mask
);

    // One mux per lane: the chunk lands only where the select matches.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [SEL_W-1:0] LANE_ID = SEL_W'(g);
        logic hit;
        assign hit = (hw_sel == LANE_ID);
        assign placed[g*CHUNK_W +: CHUNK_W]    = hit ? imm : '0;
        assign lane_mask[g*CHUNK_W +: CHUNK_W] = {CHUNK_W{hit}};
    end

endmodule

// File: rtl/mwi_decode.sv
// Module mwi_decode
// Turns the raw opcode, lane select and mode into an operation kind and an
// illegal flag. Assumes the upper half of the lanes is off-limits in narrow mode.
module mwi_decode
    import mwi_pkg::*;
#(
    parameter int LANES = 4,
    parameter int SEL_W = $clog2(LANES)
) (
    input  logic [1:0]       op_code,
    input  logic [SEL_W-1:0] hw_sel,
    input  logic             wide_mode,
    output mw_op_e           kind,
    output logic             illegal
);

    localparam int NARROW_LANES = LANES / 2;

    logic lane_out_of_range;

    // Narrow mode may address only the lower half of the lanes.
    always_comb begin
        lane_out_of_range = !wide_mode && (int'(hw_sel) >= NARROW_LANES);
    end

    // The reserved opcode or an out-of-range lane makes the operation illegal.
    always_comb begin
        kind    = mw_op_e'(op_code);
        illegal = (kind == MW_RSVD) || lane_out_of_range;
    end

endmodule

// File: rtl/mwi_merge.sv
// Module mwi_merge
// Combines the placed chunk with the prior destination according to the
// operation kind, then applies the narrow-mode width mask. Assumes the
// illegal flag is already decoded; an illegal operation yields zero.
module mwi_merge
    import mwi_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] placed,
    input  logic [DATA_W-1:0] lane_mask,
    input  logic [DATA_W-1:0] prior,
    input  mw_op_e            kind,
    input  logic              illegal,
    input  logic              wide_mode,
    output logic [DATA_W-1:0] result
);

    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] NARROW_MASK = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] width_mask;

    // Selects one of the three insert rules.
    always_comb begin
        unique case (kind)
            MW_ZERO: raw = placed;
            MW_INV:  raw = ~placed;
            MW_KEEP: raw = (prior & ~lane_mask) | placed;
            default: raw = '0;
        endcase
    end

    // Clears the upper word in narrow mode and zeroes illegal results.
    always_comb begin
        width_mask = wide_mode ? '1 : NARROW_MASK;
        result     = illegal ? '0 : (raw & width_mask);
    end

endmodule

// File: rtl/mwi_unit.sv
// Module mwi_unit (top)
// Move-wide immediate insertion with a held destination register. The
// result is combinational and uses the held value as the prior value. The
// register loads on a valid, legal strobe. Assumes a synchronous active-low reset.
module mwi_unit
    import mwi_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int CHUNK_W = 16,
    parameter int LANES   = DATA_W / CHUNK_W,
    parameter int SEL_W   = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [1:0]         op_code,
    input  logic [CHUNK_W-1:0] imm,
    input  logic [SEL_W-1:0]   hw_sel,
    input  logic               wide_mode,
    output logic [DATA_W-1:0]  result,
    output logic               illegal,
    output logic [DATA_W-1:0]  dest
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] placed;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] dest_q;
    mw_op_e            kind;
    logic              bad;

    mwi_lane_place #(
        .DATA_W (DATA_W),
        .CHUNK_W(CHUNK_W),
        .LANES  (LANES),
        .SEL_W  (SEL_W)
    ) u_place (
        .imm      (imm),
        .hw_sel   (hw_sel),
        .placed   (placed),
        .lane_mask(lane_mask)
    );

    mwi_decode #(
        .LANES(LANES),
        .SEL_W(SEL_W)
    ) u_decode (
        .op_code  (op_code),
        .hw_sel   (hw_sel),
        .wide_mode(wide_mode),
        .kind     (kind),
        .illegal  (bad)
    );

    mwi_merge #(
        .DATA_W(DATA_W)
    ) u_merge (
        .placed   (placed),
        .lane_mask(lane_mask),
        .prior    (dest_q),
        .kind     (kind),
        .illegal  (bad),
        .wide_mode(wide_mode),
        .result   (result)
    );

    // Holds the destination; loads the result on a valid, legal strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_q <= '0;
        end else if (op_valid && !bad) begin
            dest_q <= result;
        end
    end

    assign dest    = dest_q;
    assign illegal = bad;

    // R6: the reserved opcode always raises the flag.
    p_rsvd_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 2'b01) |-> illegal);

    // R6: an illegal operation produces an all-zero result.
    p_illegal_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (result == '0));

    // R5: narrow mode never produces upper-word bits.
    p_narrow_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode |-> (result[DATA_W-1:HALF_W] == '0));

    // R4: a keep insert differs from the destination only inside the lane.
    p_keep_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == MW_KEEP && !illegal && wide_mode)
            |-> (((result ^ dest_q) & ~lane_mask) == '0));

    // R7: an accepted strobe loads the result.
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !illegal) |=> (dest == $past(result)));

    // R7: without an accepted strobe the destination holds.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || illegal) |=> $stable(dest));

endmodule

// File: tb/tb_mwi_unit.sv
module tb_mwi_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'b10;
    logic [15:0] imm = '0;
    logic [1:0]  hw_sel = '0;
    logic        wide_mode = 1'b1;
    logic [63:0] result;
    logic        illegal;
    logic [63:0] dest;

    int unsigned checks = 0;
    int unsigned errs   = 0;
    logic [63:0] mdl    = '0;
    bit          done   = 1'b0;

    always #2 clk = ~clk;

    mwi_unit dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .imm      (imm),
        .hw_sel   (hw_sel),
        .wide_mode(wide_mode),
        .result   (result),
        .illegal  (illegal),
        .dest     (dest)
    );

    function automatic logic ref_bad(logic [1:0] op, logic [1:0] sh, logic w);
        return (op == 2'b01) || (!w && sh[1]);
    endfunction

    function automatic logic [63:0] ref_res(logic [1:0] op, logic [15:0] im,
                                            logic [1:0] sh, logic [63:0] prior,
                                            logic w);
        logic [63:0] placed;
        logic [63:0] m;
        logic [63:0] r;
        if (ref_bad(op, sh, w)) return 64'd0;
        placed = {48'd0, im} << (16 * sh);
        m      = 64'hFFFF << (16 * sh);
        case (op)
            2'b10:   r = placed;
            2'b00:   r = ~placed;
            default: r = (prior & ~m) | placed;
        endcase
        if (!w) r[63:32] = 32'd0;
        return r;
    endfunction

    task automatic chk64(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Drives one operation, checks the combinational outputs, then the destination.
    task automatic step(input logic v, input logic [1:0] op, input logic [15:0] im,
                        input logic [1:0] sh, input logic w, input string tag);
        logic [63:0] er;
        logic        eb;
        @(negedge clk);
        op_valid = v; op_code = op; imm = im; hw_sel = sh; wide_mode = w;
        #1;
        er = ref_res(op, im, sh, mdl, w);
        eb = ref_bad(op, sh, w);
        chk64({tag, " result"}, result, er);
        chk64({tag, " illegal"}, {63'd0, illegal}, {63'd0, eb});
        @(posedge clk);
        if (v && !eb) mdl = er;
        #1;
        chk64({tag, " dest (R7)"}, dest, mdl);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #1;
        chk64("R1 reset dest", dest, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: compose a full constant.
        step(1'b1, 2'b10, 16'h7788, 2'd0, 1'b1, "R8 zero h0");
        step(1'b1, 2'b11, 16'h5566, 2'd1, 1'b1, "R8 keep h1");
        step(1'b1, 2'b11, 16'h3344, 2'd2, 1'b1, "R8 keep h2");
        step(1'b1, 2'b11, 16'h1122, 2'd3, 1'b1, "R8 keep h3");
        chk64("R8 constant", dest, 64'h1122334455667788);

        step(1'b1, 2'b10, 16'hBEEF, 2'd3, 1'b1, "R2 zero h3");
        step(1'b1, 2'b00, 16'h0001, 2'd2, 1'b1, "R3 invert h2");
        step(1'b1, 2'b11, 16'h0000, 2'd0, 1'b1, "R4 keep h0");
        step(1'b0, 2'b10, 16'hFFFF, 2'd1, 1'b1, "R7 no strobe");
        step(1'b1, 2'b01, 16'h1234, 2'd0, 1'b1, "R6 reserved op");
        step(1'b1, 2'b10, 16'hA5A5, 2'd2, 1'b0, "R6 narrow h2");
        step(1'b1, 2'b11, 16'h5A5A, 2'd3, 1'b0, "R6 narrow h3");
        step(1'b1, 2'b00, 16'h00FF, 2'd1, 1'b0, "R5 narrow invert h1");
        step(1'b1, 2'b11, 16'hC3C3, 2'd0, 1'b0, "R5 narrow keep h0");

        // R1: reset in the middle of a run.
        step(1'b1, 2'b00, 16'h1234, 2'd0, 1'b1, "R3 invert h0");
        @(negedge clk);
        op_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        mdl = '0;
        chk64("R1 mid-run reset", dest, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 400; i++) begin
            logic [1:0] op;
            logic [1:0] sh;
            logic       w;
            logic       v;
            string      tag;
            op = 2'($urandom);
            sh = 2'($urandom);
            w  = ($urandom % 4) != 0;
            v  = ($urandom % 8) != 0;
            if (ref_bad(op, sh, w)) tag = "R6 random";
            else if (!w)            tag = "R5 random";
            else if (op == 2'b10)   tag = "R2 random";
            else if (op == 2'b00)   tag = "R3 random";
            else                    tag = "R4 random";
            step(v, op, 16'($urandom), sh, w, tag);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule